// File: doc/BRIEF.md
# Triggered Register-List Replay Engine

This block is a small bus master that plays back a list of register writes kept in memory. Each list entry is two 32-bit words: the register address comes first, and the value to write follows it. Software sets a start byte address and an inclusive last byte address for the list. It then picks what triggers the channel: an external event pulse such as vertical sync, a manual kick command, or stop. When the trigger fires, the engine reads each entry through a simple memory read port. It then issues that entry as one write on a simple register write port. Entries are handled strictly in list order.

Software reaches the engine through a write-only configuration port with four slots. They hold the start address, the last address, the trigger mode and a command word. The command word carries self-clearing kick, clear and soft-reset bits.

The start and last addresses are captured at the moment the trigger fires. Software can therefore prepare the next list while the current one is still replaying. When the final write is accepted, the engine raises a one-cycle completion pulse and a sticky completion flag, then goes idle.

Top module: `reglist_replay`

## Requirements
- R1: For an entry at byte address P, the word read at P is presented unchanged as `wr_addr`, and the word read at P+4 as `wr_data`. Addresses are not auto-incremented.
- R2: With start S and last byte L where L >= S, the list holds floor((L-S)/8)+1 entries. A last address of S+8n-1 therefore replays exactly n entries.
- R3: Entries are replayed in increasing address order, one write per entry. The next entry is fetched only after the current write is accepted (`wr_valid` and `wr_ready` both high). While it waits, `wr_addr` and `wr_data` stay stable.
- R4: Mode value 2 in configuration slot 2 is manual mode. In manual mode, a command write (slot 3) with bit 0 set starts a replay, and `evt_pulse` is ignored.
- R5: Mode value 1 is event mode. In event mode a high `evt_pulse` starts a replay, and the kick bit is ignored.
- R6: Mode value 0 (or 3) is stop. In stop, triggers are ignored. Entering stop during a replay halts it with no further writes and no completion.
- R7: A trigger that arrives while a replay is running is ignored.
- R8: The start (slot 0) and last address (slot 1) are captured when the trigger fires. Rewriting them during a replay does not change that replay.
- R9: If the last address is below the start address, a trigger issues no memory reads and no writes, and completion is signalled on the next cycle.
- R10: One cycle after the final write is accepted, `done_pulse` is high for that one cycle, `done_flag` is set and stays set, and `busy` is low.
- R11: A command write with bit 1 set clears `done_flag`. If the clear arrives in the same cycle that completion is set, the flag ends up set.
- R12: A command write with bit 2 set returns the engine to idle and clears `done_flag` without signalling completion. The address and mode settings are kept. After reset, `busy`, `done_flag`, `mem_req` and `wr_valid` are low.
- R13: A single replay issues at most MAX_ENTRIES writes, even when the list extent covers more entries than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Slot: 0 start, 1 last byte, 2 mode, 3 command |
| cfg_wdata | input | WORD_W | Configuration write data |
| evt_pulse | input | 1 | External event trigger |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | WORD_W | Byte address of the word being read |
| mem_ack | input | 1 | Read acknowledge, with data valid |
| mem_rdata | input | WORD_W | Read data |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | WORD_W | Target register address |
| wr_data | output | WORD_W | Value to write |
| wr_ready | input | 1 | Register write accepted |
| busy | output | 1 | Replay in progress |
| done_flag | output | 1 | Sticky completion flag |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land in the same cycle: completion, when the final write is accepted, and a software clear of the completion flag. The bench holds `wr_ready` low on the final entry. It then raises `wr_ready` in the same cycle as a clear command, so that both are sampled at the same clock edge. The result is judged by requiring `done_flag` to be set afterwards, with exactly one completion pulse. Trigger collisions are also provoked: kicks and event pulses arrive during a running replay, and addresses are rewritten mid-list. These are judged by the exact count and content of the writes against the list that was captured.

// File: rtl/rre_pkg.sv
package rre_pkg;
    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_LAST  = 2'd1;
    localparam logic [1:0] SEL_MODE  = 2'd2;
    localparam logic [1:0] SEL_CMD   = 2'd3;

    localparam int CMD_KICK  = 0;
    localparam int CMD_CLEAR = 1;
    localparam int CMD_SRST  = 2;

    localparam logic [1:0] MODE_STOP   = 2'd0;
    localparam logic [1:0] MODE_EVENT  = 2'd1;
    localparam logic [1:0] MODE_MANUAL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH_A = 2'd1,
        ST_FETCH_V = 2'd2,
        ST_WRITE   = 2'd3
    } seq_st_e;
endpackage

// File: rtl/rre_cfg.sv
module rre_cfg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] start_addr,
    output logic [WORD_W-1:0] last_addr,
    output logic [1:0]        mode,
    output logic              kick,
    output logic              clear,
    output logic              srst
);
    import rre_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] start;
        logic [WORD_W-1:0] last;
        logic [1:0]        mode;
    } cfg_t;

    cfg_t r_d, r_q;
    logic cmd_wr;

    always_comb begin
        r_d    = r_q;
        cmd_wr = cfg_we && (cfg_sel == SEL_CMD);
        if (cfg_we) begin
            case (cfg_sel)
                SEL_START: r_d.start = cfg_wdata;
                SEL_LAST:  r_d.last  = cfg_wdata;
                SEL_MODE:  r_d.mode  = cfg_wdata[1:0];
                default:   r_d       = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{start: '0, last: '0, mode: MODE_STOP};
        end else begin
            r_q <= r_d;
        end
    end

    assign start_addr = r_q.start;
    assign last_addr  = r_q.last;
    assign mode       = r_q.mode;
    assign kick       = cmd_wr && cfg_wdata[CMD_KICK];
    assign clear      = cmd_wr && cfg_wdata[CMD_CLEAR];
    assign srst       = cmd_wr && cfg_wdata[CMD_SRST];

    // R12: a soft reset never disturbs the stored settings
    a_r12_settings_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && !(cfg_we && cfg_sel != SEL_CMD)) |=> $stable(r_q));
endmodule

// File: rtl/rre_extent.sv
module rre_extent #(
    parameter int WORD_W      = 32,
    parameter int MAX_ENTRIES = 512,
    parameter int CNT_W       = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
    parameter int ENTRY_BYTES = 2 * (WORD_W / 8)
) (
    input  logic [WORD_W-1:0] trig_start,
    input  logic [WORD_W-1:0] trig_last,
    input  logic [WORD_W-1:0] ptr,
    input  logic [WORD_W-1:0] lim,
    input  logic [CNT_W-1:0]  cnt,
    output logic              empty,
    output logic              final_entry
);
    logic [WORD_W:0] next_ptr;
    logic            past_end;
    logic            at_cap;

    always_comb begin
        empty       = trig_last < trig_start;
        next_ptr    = {1'b0, ptr} + (WORD_W+1)'(ENTRY_BYTES);
        past_end    = next_ptr > {1'b0, lim};
        at_cap      = cnt == CNT_W'(MAX_ENTRIES - 1);
        final_entry = past_end || at_cap;
    end
endmodule

// File: rtl/rre_seq.sv
module rre_seq #(
    parameter int WORD_W      = 32,
    parameter int MAX_ENTRIES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              kick,
    input  logic              clear,
    input  logic              srst,
    input  logic              evt,
    input  logic [WORD_W-1:0] start_addr,
    input  logic [WORD_W-1:0] last_addr,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              done_flag,
    output logic              done_pulse
);
    import rre_pkg::*;

    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int ENTRY_BYTES = 2 * WORD_BYTES;
    localparam int CNT_W       = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;

    typedef struct packed {
        seq_st_e           st;
        logic [WORD_W-1:0] ptr;
        logic [WORD_W-1:0] lim;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] reg_a;
        logic [WORD_W-1:0] reg_v;
        logic              flag;
        logic              pls;
    } seq_t;

    seq_t s_d, s_q;
    logic stop_sel;
    logic fire;
    logic set_done;
    logic empty;
    logic final_entry;

    rre_extent #(
        .WORD_W      (WORD_W),
        .MAX_ENTRIES (MAX_ENTRIES),
        .CNT_W       (CNT_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) i_extent (
        .trig_start  (start_addr),
        .trig_last   (last_addr),
        .ptr         (s_q.ptr),
        .lim         (s_q.lim),
        .cnt         (s_q.cnt),
        .empty       (empty),
        .final_entry (final_entry)
    );

    always_comb begin
        s_d      = s_q;
        s_d.pls  = 1'b0;
        set_done = 1'b0;
        stop_sel = (mode != MODE_EVENT) && (mode != MODE_MANUAL);
        fire     = (s_q.st == ST_IDLE) &&
                   (((mode == MODE_EVENT) && evt) || ((mode == MODE_MANUAL) && kick));
        if (srst) begin
            s_d.st   = ST_IDLE;
            s_d.flag = 1'b0;
        end else begin
            case (s_q.st)
                ST_IDLE: begin
                    if (fire) begin
                        s_d.ptr = start_addr;
                        s_d.lim = last_addr;
                        s_d.cnt = '0;
                        if (empty) begin
                            set_done = 1'b1;
                        end else begin
                            s_d.st = ST_FETCH_A;
                        end
                    end
                end
                ST_FETCH_A: begin
                    if (stop_sel) begin
                        s_d.st = ST_IDLE;
                    end else if (mem_ack) begin
                        s_d.reg_a = mem_rdata;
                        s_d.st    = ST_FETCH_V;
                    end
                end
                ST_FETCH_V: begin
                    if (stop_sel) begin
                        s_d.st = ST_IDLE;
                    end else if (mem_ack) begin
                        s_d.reg_v = mem_rdata;
                        s_d.st    = ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (stop_sel) begin
                        s_d.st = ST_IDLE;
                    end else if (wr_ready) begin
                        if (final_entry) begin
                            set_done = 1'b1;
                            s_d.st   = ST_IDLE;
                        end else begin
                            s_d.ptr = s_q.ptr + WORD_W'(ENTRY_BYTES);
                            s_d.cnt = s_q.cnt + 1'b1;
                            s_d.st  = ST_FETCH_A;
                        end
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
            s_d.flag = set_done || (s_q.flag && !clear);
            s_d.pls  = set_done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, ptr: '0, lim: '0, cnt: '0,
                     reg_a: '0, reg_v: '0, flag: 1'b0, pls: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req    = (s_q.st == ST_FETCH_A) || (s_q.st == ST_FETCH_V);
    assign mem_addr   = (s_q.st == ST_FETCH_V) ? (s_q.ptr + WORD_W'(WORD_BYTES)) : s_q.ptr;
    assign wr_valid   = s_q.st == ST_WRITE;
    assign wr_addr    = s_q.reg_a;
    assign wr_data    = s_q.reg_v;
    assign busy       = s_q.st != ST_IDLE;
    assign done_flag  = s_q.flag;
    assign done_pulse = s_q.pls;

    // R3: a pending write keeps its address and value until accepted
    a_r3_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && !srst && !stop_sel) |=>
            (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R10: the completion pulse comes with the flag and an idle engine
    a_r10_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (done_flag && !busy));

    // R11: after a clear the flag survives only if completion was set
    a_r11_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (done_flag == done_pulse));

    // R12: soft reset idles the engine and drops the flag
    a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && !done_flag && !done_pulse));

    // R6: selecting stop during a replay halts it without completion
    a_r6_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop_sel) |=> (!busy && !done_pulse));

    // R7: no new capture while a replay is running
    a_r7_busy_keeps_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !srst) |-> $stable(s_q.lim));
endmodule

// File: rtl/reglist_replay.sv
module reglist_replay #(
    parameter int WORD_W      = 32,
    parameter int MAX_ENTRIES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              evt_pulse,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              done_flag,
    output logic              done_pulse
);
    logic [WORD_W-1:0] start_addr;
    logic [WORD_W-1:0] last_addr;
    logic [1:0]        mode;
    logic              kick;
    logic              clear;
    logic              srst;

    rre_cfg #(.WORD_W(WORD_W)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .start_addr (start_addr),
        .last_addr  (last_addr),
        .mode       (mode),
        .kick       (kick),
        .clear      (clear),
        .srst       (srst)
    );

    rre_seq #(.WORD_W(WORD_W), .MAX_ENTRIES(MAX_ENTRIES)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .kick       (kick),
        .clear      (clear),
        .srst       (srst),
        .evt        (evt_pulse),
        .start_addr (start_addr),
        .last_addr  (last_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .busy       (busy),
        .done_flag  (done_flag),
        .done_pulse (done_pulse)
    );

    // R3: fetching and writing never overlap
    a_r3_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && wr_valid));
endmodule

// File: tb/test_reglist_replay.sv
module test_reglist_replay;
    localparam int W   = 32;
    localparam int MAX = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [W-1:0]  cfg_wdata = '0;
    logic          evt_pulse = 1'b0;
    logic          mem_req;
    logic [W-1:0]  mem_addr;
    logic          mem_ack = 1'b0;
    logic [W-1:0]  mem_rdata = '0;
    logic          wr_valid;
    logic [W-1:0]  wr_addr;
    logic [W-1:0]  wr_data;
    logic          wr_ready = 1'b0;
    logic          busy;
    logic          done_flag;
    logic          done_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int hs_total = 0;
    int pulses = 0;
    int req_total = 0;
    int last_hs_cyc = 0;
    int done_cyc = 0;
    int ready_mode = 0;
    logic [W-1:0] log_a [0:2047];
    logic [W-1:0] log_d [0:2047];

    reglist_replay #(.WORD_W(W), .MAX_ENTRIES(MAX)) i_reglist_replay (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .evt_pulse(evt_pulse), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .busy(busy), .done_flag(done_flag),
        .done_pulse(done_pulse)
    );

    always #5 clk = ~clk;

    function automatic logic [W-1:0] patt(logic [W-1:0] b);
        return {b[15:0], ~b[15:0]};
    endfunction

    function automatic int exp_n(logic [W-1:0] s, logic [W-1:0] e);
        int n;
        if (e < s) return 0;
        n = int'((e - s) >> 3) + 1;
        return (n > MAX) ? MAX : n;
    endfunction

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= patt(mem_addr);
    end

    always @(negedge clk) begin
        if (ready_mode == 0) wr_ready = 1'b1;
        else if (ready_mode == 1) wr_ready = ~wr_ready;
    end

    // monitor at the edge where the design samples
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (wr_valid && wr_ready) begin
            log_a[hs_total[10:0]] = wr_addr;
            log_d[hs_total[10:0]] = wr_data;
            hs_total = hs_total + 1;
            last_hs_cyc = cyc;
        end
        if (done_pulse) begin
            pulses = pulses + 1;
            done_cyc = cyc;
        end
        if (mem_req) req_total = req_total + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_evt();
        @(negedge clk); evt_pulse = 1'b1;
        @(negedge clk); evt_pulse = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (busy) check(1'b0, "watch busy", 1, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_writes(input int base, input int k);
        int t = 0;
        while ((hs_total - base) < k && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic check_list(input int base, input logic [W-1:0] s, input int n, input string req);
        int bad = 0;
        int first = -1;
        for (int k = 0; k < n; k++) begin
            if (log_a[(base + k) % 2048] !== patt(s + 32'(8 * k)) ||
                log_d[(base + k) % 2048] !== patt(s + 32'(8 * k + 4))) begin
                bad++;
                if (first < 0) first = k;
            end
        end
        check(bad == 0, req, first, -1);
    endtask

    task automatic run_case(input logic [W-1:0] s, input logic [W-1:0] e, input int rmode);
        int base, p0, r0, n;
        ready_mode = rmode;
        cfg_write(rre_pkg::SEL_START, s);
        cfg_write(rre_pkg::SEL_LAST, e);
        base = hs_total; p0 = pulses; r0 = req_total;
        n = exp_n(s, e);
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        wait_idle();
        check((hs_total - base) == n, "R2 R13 write count", hs_total - base, n);
        check_list(base, s, n, "R1 R3 entry content/order");
        check((pulses - p0) == 1, "R10 one done pulse", pulses - p0, 1);
        if (n == 0) begin
            check((req_total - r0) == 0, "R9 no reads for empty list", req_total - r0, 0);
        end else begin
            check(done_cyc == last_hs_cyc + 1, "R10 pulse timing", done_cyc - last_hs_cyc, 1);
        end
        check(done_flag == 1'b1, "R10 sticky flag", int'(done_flag), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures = failures + 1;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base, p0, r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done_flag && !mem_req && !wr_valid, "R12 reset state",
              int'({busy, done_flag, mem_req, wr_valid}), 0);

        cfg_write(rre_pkg::SEL_MODE, 32'd2);

        // sweep lengths, alignments, starts and write stalls
        for (int si = 0; si < 2; si++) begin
            for (int n = 0; n <= MAX + 2; n++) begin
                for (int ki = 0; ki < 2; ki++) begin
                    logic [W-1:0] s;
                    s = (si == 0) ? 32'h100 : 32'h3F0;
                    run_case(s, s + 32'(8 * n) - 32'd1 + 32'(4 * ki), (n + ki + si) % 2);
                end
            end
        end

        // R11: clear drops the flag
        cfg_write(rre_pkg::SEL_CMD, 32'd2);
        check(done_flag == 1'b0, "R11 clear", int'(done_flag), 0);

        // R4: event pulse ignored in manual mode
        base = hs_total; r0 = req_total;
        cfg_write(rre_pkg::SEL_START, 32'h200);
        cfg_write(rre_pkg::SEL_LAST, 32'h200 + 32'd23);
        pulse_evt();
        repeat (10) @(negedge clk);
        check((req_total - r0) == 0 && !busy, "R4 evt ignored in manual", req_total - r0, 0);

        // R5: event mode starts on evt, kick ignored
        cfg_write(rre_pkg::SEL_MODE, 32'd1);
        r0 = req_total;
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        repeat (10) @(negedge clk);
        check((req_total - r0) == 0 && !busy, "R5 kick ignored in event", req_total - r0, 0);
        base = hs_total; p0 = pulses;
        pulse_evt();
        wait_idle();
        check((hs_total - base) == 3, "R5 event replay count", hs_total - base, 3);
        check_list(base, 32'h200, 3, "R5 event replay content");
        check((pulses - p0) == 1, "R5 event done", pulses - p0, 1);

        // R6: stop mode ignores triggers
        cfg_write(rre_pkg::SEL_MODE, 32'd0);
        r0 = req_total;
        pulse_evt();
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        repeat (10) @(negedge clk);
        check((req_total - r0) == 0 && !busy, "R6 stop ignores triggers", req_total - r0, 0);

        // R6: stop mid replay
        cfg_write(rre_pkg::SEL_MODE, 32'd2);
        ready_mode = 0;
        cfg_write(rre_pkg::SEL_START, 32'h400);
        cfg_write(rre_pkg::SEL_LAST, 32'h400 + 32'd63);
        base = hs_total; p0 = pulses;
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        wait_writes(base, 2);
        cfg_write(rre_pkg::SEL_MODE, 32'd0);
        wait_idle();
        check(!busy && (pulses - p0) == 0, "R6 stop halts without done", pulses - p0, 0);
        check((hs_total - base) < 8, "R6 stop cuts list", hs_total - base, 7);

        // R7: triggers during a replay are ignored
        cfg_write(rre_pkg::SEL_MODE, 32'd2);
        ready_mode = 1;
        cfg_write(rre_pkg::SEL_LAST, 32'h400 + 32'd39);
        base = hs_total; p0 = pulses;
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        pulse_evt();
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        wait_idle();
        check((hs_total - base) == 5, "R7 retrigger ignored count", hs_total - base, 5);
        check((pulses - p0) == 1, "R7 one completion", pulses - p0, 1);

        // R8: addresses captured at trigger
        cfg_write(rre_pkg::SEL_START, 32'h100);
        cfg_write(rre_pkg::SEL_LAST, 32'h100 + 32'd47);
        base = hs_total;
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        wait_writes(base, 1);
        cfg_write(rre_pkg::SEL_START, 32'h800);
        cfg_write(rre_pkg::SEL_LAST, 32'h800 + 32'd15);
        wait_idle();
        check((hs_total - base) == 6, "R8 captured count", hs_total - base, 6);
        check_list(base, 32'h100, 6, "R8 captured content");

        // R12: soft reset mid replay, settings kept
        ready_mode = 0;
        cfg_write(rre_pkg::SEL_START, 32'h500);
        cfg_write(rre_pkg::SEL_LAST, 32'h500 + 32'd63);
        base = hs_total; p0 = pulses;
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        wait_writes(base, 2);
        check(done_flag == 1'b1, "R12 flag set before soft reset", int'(done_flag), 1);
        cfg_write(rre_pkg::SEL_CMD, 32'd4);
        check(!busy && !done_flag, "R12 soft reset idles and clears",
              int'({busy, done_flag}), 0);
        repeat (5) @(negedge clk);
        check((pulses - p0) == 0, "R12 no completion on soft reset", pulses - p0, 0);
        base = hs_total;
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        wait_idle();
        check((hs_total - base) == 8, "R12 settings kept", hs_total - base, 8);
        check_list(base, 32'h500, 8, "R12 replay after soft reset");

        // R11: clear coincident with completion, set wins
        ready_mode = 2;
        wr_ready = 1'b0;
        cfg_write(rre_pkg::SEL_CMD, 32'd2);
        cfg_write(rre_pkg::SEL_START, 32'h600);
        cfg_write(rre_pkg::SEL_LAST, 32'h600 + 32'd23);
        base = hs_total; p0 = pulses;
        cfg_write(rre_pkg::SEL_CMD, 32'd1);
        begin
            int t = 0;
            while (t < 3000) begin
                @(negedge clk);
                t++;
                if (wr_valid && (hs_total - base) < 2) wr_ready = 1'b1;
                else wr_ready = 1'b0;
                if (wr_valid && (hs_total - base) == 2) break;
            end
        end
        wr_ready = 1'b1;
        cfg_we = 1'b1; cfg_sel = rre_pkg::SEL_CMD; cfg_wdata = 32'd2;
        @(negedge clk);
        wr_ready = 1'b0;
        cfg_we = 1'b0;
        @(negedge clk);
        check(done_flag == 1'b1, "R11 set wins over clear", int'(done_flag), 1);
        check((pulses - p0) == 1 && (hs_total - base) == 3, "R11 coincident completion",
              pulses - p0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule